// File: doc/BRIEF.md
# Serial Register Front End for a Timekeeping Peripheral

This block terminates a byte-wide serial peripheral bus on the register side of a small real-time-clock peripheral. A host raises chip select, sends one command byte holding a direction bit and a 7-bit start address, and then moves any number of data bytes. The address steps by one after every data byte, so a single transaction can move a whole group of time, alarm or configuration registers.

The block holds the control register, the alarm status flags, the charger configuration byte and a general-purpose RAM. It forwards the low address window, which holds the time and alarm registers, to a neighbouring block through a strobe-style port. A write-protect bit in the control register shields every location from writes, except for a control write that turns the protection off. Reading an alarm register acknowledges that alarm's flag.

All bus pins are sampled in the system clock domain through synchronisers. The serial clock must therefore run well below the system clock; at least eight system clocks per serial half period is enough.

Top module: `spi_rtc_regif`

## Requirements
- R1: The first byte after chip select goes high is a command. Bit 7 set means a write and bit 7 clear means a read. Bits 6:0 give the start address.
- R2: With `IDLE_HIGH`=0 the serial clock idles low. MOSI is captured on the edge that returns the clock to idle, and MISO changes on the edge that leaves idle. Bytes travel MSB first.
- R3: Each data byte advances the address by one, and address 0x7F is followed by 0x00.
- R4: Chip select going low ends the transaction and clears the bit count, so a partial byte is dropped. MISO is low while chip select is low.
- R5: The control register is at 0x0F. Bit 7 is oscillator disable, bit 6 is write protect, bit 2 selects interrupt routing or 1 Hz output, and bits 1:0 enable the alarm 1 and alarm 0 interrupts. Bits 5:3 always read 0. After reset the register holds 0xC0.
- R6: The status register is at 0x10. Bits 1:0 are the alarm 1 and alarm 0 flags, and bits 7:2 read 0. A one-cycle pulse on `alm_hit[n]` sets flag n. Writing status clears each flag whose written bit is 0. A set on the same cycle as a clear wins.
- R7: Fetching a byte from 0x07..0x0A clears flag 0, and fetching from 0x0B..0x0E clears flag 1. A read burst fetches the next byte as soon as the previous byte completes.
- R8: Address 0x11 is an 8-bit charger configuration byte that resets to 0. `charger_valid` is high exactly when its upper nibble equals 0xA.
- R9: Addresses 0x20..0x7F are 96 bytes of RAM that reset to zero. Addresses 0x12..0x1F read 0 and ignore writes.
- R10: While write protect is set, writes to every address other than 0x0F are ignored, including writes forwarded to the neighbour. A write to 0x0F takes effect only if it clears bit 6.
- R11: Addresses 0x00..0x0E go to the neighbour. A write gives a one-cycle `nb_we` with `nb_addr` and `nb_wdata`. A fetch gives a one-cycle `nb_re` and returns `nb_rdata` from the same cycle.
- R12: `alarm_irq` is high while any alarm flag is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| nb_addr | output | 7 | Address presented to the time/alarm neighbour |
| nb_we | output | 1 | Neighbour write strobe |
| nb_re | output | 1 | Neighbour read strobe |
| nb_wdata | output | 8 | Neighbour write data |
| nb_rdata | input | 8 | Neighbour read data, valid in the strobe cycle |
| alm_hit | input | 2 | Alarm match pulses from the neighbour |
| ctrl_o | output | 8 | Current control register |
| alarm_flags | output | 2 | Alarm flags as in the status register |
| alarm_irq | output | 1 | Alarm interrupt request |
| charger_cfg | output | 8 | Charger configuration byte |
| charger_valid | output | 1 | Charger key nibble matches |

## Verification
The bench builds the block with its defaults: two synchroniser stages, a serial clock that idles low, 96 bytes of RAM from 0x20, and key nibble 0xA. With these values the RAM ends at the top of the address space. A write burst starting at 0x7E therefore crosses the wrap into the neighbour window at 0x00, which checks increment, wrap and forwarding in one transaction. A small model of the neighbour in the bench also lets write protect be observed on forwarded writes, and lets read strobes be counted across the prefetch at the edge of the window.

// File: rtl/spi_rtc_pkg.sv
package spi_rtc_pkg;

    localparam int ADDR_W = 7;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [7:0]        byte_t;

    localparam addr_t A_NB_LAST = 7'h0E;
    localparam addr_t A_CTRL    = 7'h0F;
    localparam addr_t A_STAT    = 7'h10;
    localparam addr_t A_CHG     = 7'h11;

    localparam int    WP_BIT    = 6;
    localparam byte_t CTRL_MASK = 8'hC7;
    localparam byte_t CTRL_RST  = 8'hC0;

    typedef enum logic [2:0] {
        K_NB, K_CTRL, K_STAT, K_CHG, K_RAM, K_NONE
    } reg_kind_e;

    // one register access produced by the transaction sequencer
    typedef struct packed {
        logic  stb;
        logic  wr;
        addr_t addr;
        byte_t data;
    } reg_op_t;

    function automatic reg_kind_e classify(addr_t a, int ram_base, int ram_bytes);
        if (a <= A_NB_LAST)                                  return K_NB;
        if (a == A_CTRL)                                     return K_CTRL;
        if (a == A_STAT)                                     return K_STAT;
        if (a == A_CHG)                                      return K_CHG;
        if (int'(a) >= ram_base && int'(a) < ram_base + ram_bytes) return K_RAM;
        return K_NONE;
    endfunction

    // which alarm flag a fetch from this address acknowledges
    function automatic logic [1:0] alarm_ack(addr_t a);
        logic [1:0] m;
        m[0] = (a >= 7'h07) && (a <= 7'h0A);
        m[1] = (a >= 7'h0B) && (a <= 7'h0E);
        return m;
    endfunction

endpackage

// File: rtl/spi_rtc_edge.sv
module spi_rtc_edge #(
    parameter int SYNC_STAGES = 2,
    parameter bit IDLE_HIGH   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs,
    input  logic mosi,
    output logic cs_s,
    output logic mosi_s,
    output logic lead,
    output logic trail
);
    logic [SYNC_STAGES-1:0] sck_sr, cs_sr, mosi_sr;
    logic                   sck_prev, sck_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sr   <= {SYNC_STAGES{IDLE_HIGH}};
            cs_sr    <= '0;
            mosi_sr  <= '0;
            sck_prev <= IDLE_HIGH;
        end else begin
            sck_sr   <= {sck_sr[SYNC_STAGES-2:0], sck};
            cs_sr    <= {cs_sr[SYNC_STAGES-2:0], cs};
            mosi_sr  <= {mosi_sr[SYNC_STAGES-2:0], mosi};
            sck_prev <= sck_now;
        end
    end

    assign sck_now = sck_sr[SYNC_STAGES-1];
    assign cs_s    = cs_sr[SYNC_STAGES-1];
    assign mosi_s  = mosi_sr[SYNC_STAGES-1];

    generate
        if (IDLE_HIGH) begin : g_idle_hi
            assign lead  =  sck_prev & ~sck_now;
            assign trail = ~sck_prev &  sck_now;
        end else begin : g_idle_lo
            assign lead  = ~sck_prev &  sck_now;
            assign trail =  sck_prev & ~sck_now;
        end
    endgenerate

endmodule

// File: rtl/spi_rtc_shifter.sv
module spi_rtc_shifter
    import spi_rtc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_s,
    input  logic  mosi_s,
    input  logic  lead,
    input  logic  trail,
    input  logic  load,
    input  byte_t load_data,
    output logic  byte_vld,
    output byte_t byte_q,
    output logic  miso
);
    logic [2:0] bit_cnt;
    byte_t      rx_sr, tx_sr;
    logic       miso_q;

    always_ff @(posedge clk) begin
        if (rst || !cs_s) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            miso_q   <= 1'b0;
            byte_vld <= 1'b0;
            byte_q   <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (trail) begin
                rx_sr   <= {rx_sr[6:0], mosi_s};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_vld <= 1'b1;
                    byte_q   <= {rx_sr[6:0], mosi_s};
                end
            end
            if (load) begin
                tx_sr <= load_data;
            end else if (lead) begin
                miso_q <= tx_sr[7];
                tx_sr  <= {tx_sr[6:0], 1'b0};
            end
        end
    end

    assign miso = miso_q;

endmodule

// File: rtl/spi_rtc_xact.sv
module spi_rtc_xact
    import spi_rtc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_s,
    input  logic    byte_vld,
    input  byte_t   byte_q,
    output reg_op_t op
);
    logic  first;
    logic  wr_mode;
    addr_t next_addr;

    always_ff @(posedge clk) begin
        if (rst || !cs_s) begin
            first     <= 1'b1;
            wr_mode   <= 1'b0;
            next_addr <= '0;
            op        <= '0;
        end else begin
            op.stb <= 1'b0;
            if (byte_vld) begin
                if (first) begin
                    first   <= 1'b0;
                    wr_mode <= byte_q[7];
                    if (byte_q[7]) begin
                        next_addr <= byte_q[6:0];
                    end else begin
                        // fetch the first read byte at once
                        op        <= '{stb: 1'b1, wr: 1'b0, addr: byte_q[6:0], data: '0};
                        next_addr <= byte_q[6:0] + 7'd1;
                    end
                end else begin
                    op        <= '{stb: 1'b1, wr: wr_mode, addr: next_addr, data: byte_q};
                    next_addr <= next_addr + 7'd1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_rtc_regs.sv
module spi_rtc_regs
    import spi_rtc_pkg::*;
#(
    parameter int         RAM_BASE  = 32,
    parameter int         RAM_BYTES = 96,
    parameter logic [3:0] CHG_KEY   = 4'hA
) (
    input  logic       clk,
    input  logic       rst,
    input  reg_op_t    op,
    input  logic [1:0] alm_hit,
    input  byte_t      nb_rdata,
    output byte_t      rd_data,
    output logic       rd_load,
    output addr_t      nb_addr,
    output logic       nb_we,
    output logic       nb_re,
    output byte_t      nb_wdata,
    output byte_t      ctrl_o,
    output logic [1:0] alarm_flags,
    output logic       alarm_irq,
    output byte_t      charger_cfg,
    output logic       charger_valid
);
    localparam int RAM_AW = $clog2(RAM_BYTES);

    byte_t        ctrl_q, chg_q;
    logic [1:0]   stat_q;
    byte_t        ram [RAM_BYTES];
    reg_kind_e    kind;
    logic         wp, rd, wr_ok;
    addr_t        ram_off;
    logic [RAM_AW-1:0] ram_idx;
    logic [1:0]   ack_clr, wr_clr;

    assign kind    = classify(op.addr, RAM_BASE, RAM_BYTES);
    assign wp      = ctrl_q[WP_BIT];
    assign rd      = op.stb && !op.wr;
    // protect gate: only a control write that drops the protect bit passes
    assign wr_ok   = op.stb && op.wr &&
                     (!wp || (kind == K_CTRL && !op.data[WP_BIT]));
    assign ram_off = op.addr - addr_t'(RAM_BASE);
    assign ram_idx = ram_off[RAM_AW-1:0];
    assign ack_clr = rd ? alarm_ack(op.addr) : 2'b00;
    assign wr_clr  = (wr_ok && kind == K_STAT) ? ~op.data[1:0] : 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            chg_q  <= '0;
            stat_q <= '0;
        end else begin
            if (wr_ok && kind == K_CTRL) ctrl_q <= op.data & CTRL_MASK;
            if (wr_ok && kind == K_CHG)  chg_q  <= op.data;
            stat_q <= alm_hit | (stat_q & ~ack_clr & ~wr_clr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RAM_BYTES; i++) ram[i] <= '0;
        end else if (wr_ok && kind == K_RAM) begin
            ram[ram_idx] <= op.data;
        end
    end

    always_comb begin
        unique case (kind)
            K_NB:    rd_data = nb_rdata;
            K_CTRL:  rd_data = ctrl_q;
            K_STAT:  rd_data = {6'b0, stat_q};
            K_CHG:   rd_data = chg_q;
            K_RAM:   rd_data = ram[ram_idx];
            default: rd_data = '0;
        endcase
    end

    assign rd_load       = rd;
    assign nb_addr       = op.addr;
    assign nb_wdata      = op.data;
    assign nb_we         = wr_ok && kind == K_NB;
    assign nb_re         = rd && kind == K_NB;
    assign ctrl_o        = ctrl_q;
    assign alarm_flags   = stat_q;
    assign alarm_irq     = |(stat_q & ctrl_q[1:0]);
    assign charger_cfg   = chg_q;
    assign charger_valid = (chg_q[7:4] == CHG_KEY);

endmodule

// File: rtl/spi_rtc_regif.sv
module spi_rtc_regif
    import spi_rtc_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter bit         IDLE_HIGH   = 1'b0,
    parameter int         RAM_BASE    = 32,
    parameter int         RAM_BYTES   = 96,
    parameter logic [3:0] CHG_KEY     = 4'hA
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_sck,
    input  logic       spi_cs,
    input  logic       spi_mosi,
    output logic       spi_miso,
    output logic [6:0] nb_addr,
    output logic       nb_we,
    output logic       nb_re,
    output logic [7:0] nb_wdata,
    input  logic [7:0] nb_rdata,
    input  logic [1:0] alm_hit,
    output logic [7:0] ctrl_o,
    output logic [1:0] alarm_flags,
    output logic       alarm_irq,
    output logic [7:0] charger_cfg,
    output logic       charger_valid
);
    logic    cs_s, mosi_s, lead, trail;
    logic    byte_vld, rd_load;
    byte_t   byte_q, rd_data;
    reg_op_t op;

    spi_rtc_edge #(
        .SYNC_STAGES (SYNC_STAGES),
        .IDLE_HIGH   (IDLE_HIGH)
    ) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sck    (spi_sck),
        .cs     (spi_cs),
        .mosi   (spi_mosi),
        .cs_s   (cs_s),
        .mosi_s (mosi_s),
        .lead   (lead),
        .trail  (trail)
    );

    spi_rtc_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .cs_s      (cs_s),
        .mosi_s    (mosi_s),
        .lead      (lead),
        .trail     (trail),
        .load      (rd_load),
        .load_data (rd_data),
        .byte_vld  (byte_vld),
        .byte_q    (byte_q),
        .miso      (spi_miso)
    );

    spi_rtc_xact u_xact (
        .clk      (clk),
        .rst      (rst),
        .cs_s     (cs_s),
        .byte_vld (byte_vld),
        .byte_q   (byte_q),
        .op       (op)
    );

    spi_rtc_regs #(
        .RAM_BASE  (RAM_BASE),
        .RAM_BYTES (RAM_BYTES),
        .CHG_KEY   (CHG_KEY)
    ) u_regs (
        .clk           (clk),
        .rst           (rst),
        .op            (op),
        .alm_hit       (alm_hit),
        .nb_rdata      (nb_rdata),
        .rd_data       (rd_data),
        .rd_load       (rd_load),
        .nb_addr       (nb_addr),
        .nb_we         (nb_we),
        .nb_re         (nb_re),
        .nb_wdata      (nb_wdata),
        .ctrl_o        (ctrl_o),
        .alarm_flags   (alarm_flags),
        .alarm_irq     (alarm_irq),
        .charger_cfg   (charger_cfg),
        .charger_valid (charger_valid)
    );

endmodule

// File: rtl/spi_rtc_regif_chk.sv
module spi_rtc_regif_chk
    import spi_rtc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cs_s,
    input logic       spi_miso,
    input logic [1:0] alm_hit,
    input logic [1:0] alarm_flags,
    input reg_op_t    op,
    input logic [7:0] ctrl_o,
    input logic       nb_we,
    input logic       nb_re,
    input logic       alarm_irq
);
    AST_MISO_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !cs_s |=> !spi_miso); // R4

    AST_FLAG0_SET: assert property (@(posedge clk) disable iff (rst)
        alm_hit[0] |=> alarm_flags[0]); // R6

    AST_FLAG1_SET: assert property (@(posedge clk) disable iff (rst)
        alm_hit[1] |=> alarm_flags[1]); // R6

    AST_ALM0_FETCH_ACK: assert property (@(posedge clk) disable iff (rst)
        (op.stb && !op.wr && op.addr >= 7'h07 && op.addr <= 7'h0A && !alm_hit[0])
        |=> !alarm_flags[0]); // R7

    AST_PROTECT_NB: assert property (@(posedge clk) disable iff (rst)
        ctrl_o[WP_BIT] |-> !nb_we); // R10

    AST_PROTECT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ctrl_o[WP_BIT] && !(op.stb && op.wr && op.addr == A_CTRL))
        |=> ctrl_o[WP_BIT]); // R10

    AST_NB_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({nb_we, nb_re})); // R11

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> (alarm_flags != 2'b00)); // R12

endmodule

bind spi_rtc_regif spi_rtc_regif_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_s        (cs_s),
    .spi_miso    (spi_miso),
    .alm_hit     (alm_hit),
    .alarm_flags (alarm_flags),
    .op          (op),
    .ctrl_o      (ctrl_o),
    .nb_we       (nb_we),
    .nb_re       (nb_re),
    .alarm_irq   (alarm_irq)
);

// File: tb/spi_rtc_regif_tb.sv
`timescale 1ns/1ps
module spi_rtc_regif_tb;

    localparam int H = 8;   // system clocks per serial half period

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_sck = 1'b0, spi_cs = 1'b0, spi_mosi = 1'b0;
    logic       spi_miso;
    logic [6:0] nb_addr;
    logic       nb_we, nb_re;
    logic [7:0] nb_wdata, nb_rdata;
    logic [1:0] alm_hit = 2'b00;
    logic [7:0] ctrl_o, charger_cfg;
    logic [1:0] alarm_flags;
    logic       alarm_irq, charger_valid;

    int checks = 0, failures = 0;
    int nb_re_cnt = 0;
    bit done = 1'b0;
    logic [7:0] nb_mem [15];

    always #4 clk = ~clk;

    spi_rtc_regif u_dut (
        .clk (clk), .rst (rst),
        .spi_sck (spi_sck), .spi_cs (spi_cs), .spi_mosi (spi_mosi), .spi_miso (spi_miso),
        .nb_addr (nb_addr), .nb_we (nb_we), .nb_re (nb_re),
        .nb_wdata (nb_wdata), .nb_rdata (nb_rdata), .alm_hit (alm_hit),
        .ctrl_o (ctrl_o), .alarm_flags (alarm_flags), .alarm_irq (alarm_irq),
        .charger_cfg (charger_cfg), .charger_valid (charger_valid)
    );

    // neighbour model: 15 plain bytes at 0x00..0x0E
    assign nb_rdata = (nb_addr < 7'd15) ? nb_mem[nb_addr] : 8'h00;
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 15; i++) nb_mem[i] <= 8'h00;
        end else if (nb_we && nb_addr < 7'd15) begin
            nb_mem[nb_addr] <= nb_wdata;
        end
        if (!rst && nb_re) nb_re_cnt <= nb_re_cnt + 1;
    end

    // {address, write data, expected read-back}
    localparam int NV = 12;
    localparam logic [23:0] VEC [NV] = '{
        {8'h20, 8'h5A, 8'h5A},  // R9 first RAM byte
        {8'h21, 8'h81, 8'h81},  // R2 MSB-first ordering
        {8'h45, 8'h3C, 8'h3C},  // R9 mid RAM
        {8'h7F, 8'hA5, 8'hA5},  // R9 last RAM byte
        {8'h11, 8'hA3, 8'hA3},  // R8 charger byte
        {8'h12, 8'hFF, 8'h00},  // R9 unmapped hole
        {8'h1F, 8'h11, 8'h00},  // R9 unmapped hole end
        {8'h03, 8'h42, 8'h42},  // R11 neighbour window
        {8'h0E, 8'h99, 8'h99},  // R11 neighbour window top
        {8'h10, 8'hFF, 8'h00},  // R6 status with no flags
        {8'h0F, 8'h3F, 8'h07},  // R5 reserved bits drop
        {8'h0F, 8'hB8, 8'h80}   // R5 oscillator bit kept
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_x();
        spi_cs = 1'b1;
        wclk(H);
    endtask

    task automatic end_x();
        wclk(H);
        spi_cs = 1'b0;
        wclk(2 * H);
    endtask

    // leading edge: host changes MOSI; trailing edge: device captures
    task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            spi_sck  = 1'b1;
            spi_mosi = t[i];
            wclk(H);
            r[i]     = spi_miso;
            spi_sck  = 1'b0;
            wclk(H);
        end
    endtask

    task automatic spi_wr(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] junk;
        begin_x();
        xbyte({1'b1, a}, junk);
        xbyte(d, junk);
        end_x();
    endtask

    task automatic spi_rd(input logic [6:0] a, output logic [7:0] d);
        logic [7:0] junk;
        begin_x();
        xbyte({1'b0, a}, junk);
        xbyte(8'h00, d);
        end_x();
    endtask

    task automatic pulse_hit(input logic [1:0] m);
        alm_hit = m;
        wclk(1);
        alm_hit = 2'b00;
        wclk(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, junk;
        int c0;
        wclk(5);
        rst = 1'b0;
        wclk(3);

        // reset state
        chk("R5 reset ctrl", ctrl_o, 8'hC0);
        chk("R6 reset flags", alarm_flags, 2'b00);
        chk("R8 reset charger_valid", charger_valid, 1'b0);
        chk("R4 miso idle", spi_miso, 1'b0);

        // R1 command byte selects read of control
        spi_rd(7'h0F, d);
        chk("R1 read ctrl", d, 8'hC0);

        // R10 write protect
        spi_wr(7'h20, 8'h77);
        spi_rd(7'h20, d);
        chk("R10 RAM write blocked", d, 8'h00);
        spi_wr(7'h0F, 8'hC1);
        chk("R10 ctrl write keeping protect ignored", ctrl_o, 8'hC0);
        spi_wr(7'h02, 8'h55);
        spi_rd(7'h02, d);
        chk("R10 neighbour write blocked", d, 8'h00);
        spi_wr(7'h0F, 8'h00);
        chk("R10 protect cleared", ctrl_o, 8'h00);

        // table walk
        for (int k = 0; k < NV; k++) begin
            spi_wr(VEC[k][22:16], VEC[k][15:8]);
            spi_rd(VEC[k][22:16], d);
            chk($sformatf("R2 table[%0d] addr %0h", k, VEC[k][23:16]), d, VEC[k][7:0]);
        end
        chk("R5 ctrl port after table", ctrl_o, 8'h80);
        spi_wr(7'h0F, 8'h00);

        // R8 charger key
        chk("R8 key valid", charger_valid, 1'b1);
        spi_wr(7'h11, 8'h53);
        chk("R8 key invalid", charger_valid, 1'b0);
        chk("R8 charger port", charger_cfg, 8'h53);

        // R3 burst across wrap
        begin_x();
        xbyte(8'hFE, junk);
        xbyte(8'h11, junk);
        xbyte(8'h22, junk);
        xbyte(8'h33, junk);
        end_x();
        begin_x();
        xbyte(8'h7E, junk);
        xbyte(8'h00, d); chk("R3 burst 0x7E", d, 8'h11);
        xbyte(8'h00, d); chk("R3 burst 0x7F", d, 8'h22);
        xbyte(8'h00, d); chk("R3 burst wrap 0x00", d, 8'h33);
        end_x();

        // R11 one neighbour fetch for a read at the window top
        c0 = nb_re_cnt;
        spi_rd(7'h0E, d);
        chk("R11 nb_re count", nb_re_cnt - c0, 1);

        // R4 abort mid-byte
        begin_x();
        for (int i = 0; i < 4; i++) begin
            spi_sck = 1'b1; spi_mosi = 1'b1; wclk(H);
            spi_sck = 1'b0; wclk(H);
        end
        spi_cs = 1'b0;
        wclk(2 * H);
        chk("R4 miso low after abort", spi_miso, 1'b0);
        spi_rd(7'h20, d);
        chk("R4 fresh command after abort", d, 8'h5A);

        // R6 / R7 / R12 alarm flags
        pulse_hit(2'b01);
        chk("R6 flag0 set", alarm_flags, 2'b01);
        chk("R12 irq masked", alarm_irq, 1'b0);
        spi_wr(7'h0F, 8'h01);
        chk("R12 irq enabled", alarm_irq, 1'b1);
        spi_rd(7'h10, d);
        chk("R6 status read", d, 8'h01);
        spi_rd(7'h08, d);
        chk("R7 alarm0 read acks", alarm_flags, 2'b00);
        chk("R12 irq drops", alarm_irq, 1'b0);
        pulse_hit(2'b10);
        spi_wr(7'h10, 8'h01);
        chk("R6 write zero clears flag1", alarm_flags, 2'b00);
        pulse_hit(2'b11);
        spi_wr(7'h10, 8'h02);
        chk("R6 write keeps flag1", alarm_flags, 2'b10);
        spi_rd(7'h0B, d);
        chk("R7 alarm1 read acks", alarm_flags, 2'b00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule